// File: doc/BRIEF.md
# Free-Running Xoroshiro128** Generator with Per-Core Fan-Out

This block holds a 128-bit xoroshiro128** generator that steps on every clock cycle once reset is released. Each cycle it scrambles the first state word into a 64-bit random word. That word goes out unchanged, and it is also spread across a set of consumer ports. Each consumer port carries a 32-bit word whose bits are drawn from the 64-bit output through a fixed permutation of its own.

The seed is loaded while reset is held. An all-zero seed would lock the generator, so a fixed nonzero pair of constants replaces it. The output word and the consumer words are registered, so they show the scrambled value of the state that was present before the last clock edge. Both multiplications in the scrambler are built from shifts and adds. Consumers may sample the words at any rate, because every port holds a valid word on every cycle.

Top module: `xrng_fanout`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `rnd_o` and every consumer word read zero after that edge, and the state words are loaded as s0 = `seed[63:0]` and s1 = `seed[127:64]`.
- R2: If `seed` is all zeros during reset, the state is loaded with s0 = 64'h9E3779B97F4A7C15 and s1 = 64'hD1B54A32D192ED03.
- R3: After the first rising edge with `rst_n` high, `rnd_o` equals the scrambled value of the seeded s0. This gives one cycle of latency from state to output.
- R4: The scrambled value of a state word x is rotl(x*5 mod 2^64, 7) * 9 mod 2^64.
- R5: On each edge with `rst_n` high, with t = s0 ^ s1, the new s0 is rotl(s0,24) ^ t ^ (t<<16) and the new s1 is rotl(t,37).
- R6: The state changes on every clock edge after reset and never becomes all zeros.
- R7: Consumer k sits at `core_o[32k+31:32k]`. Its bit j equals `rnd_o` bit ((j*(2k+3) + 7k) mod 64) in the same cycle, so no two consumers use the same bit selection.
- R8: Changes on `seed` while `rst_n` is high have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset that also loads the seed |
| seed | input | 128 | Seed; low half goes to s0, high half goes to s1 |
| rnd_o | output | 64 | Registered scrambled generator word |
| core_o | output | 256 | Eight 32-bit permuted consumer words, consumer k at bits 32k+31:32k |

## Verification
The bench runs a reference generator that uses true multiplies and compares it, cycle by cycle, against the output and all eight consumer words. A design that got the shift-and-add scrambler or a rotation amount wrong would diverge within a few cycles. A design that skipped the output register would be one step early on the first cycle after reset. The bench also drives an all-zero seed, which would freeze the output at zero if the substitution were missing. It changes the seed in the middle of a run, which would break the sequence if the seed leaked past reset. Each consumer word is checked bit by bit against its own permutation formula, so a wrong offset or stride, or two consumers sharing a mapping, is reported.

// File: rtl/xrng_fanout.sv
module xrng_fanout #(
  parameter int          NCORE = 8,
  parameter int          CW    = 32,
  parameter logic [63:0] ZS0   = 64'h9E3779B97F4A7C15,
  parameter logic [63:0] ZS1   = 64'hD1B54A32D192ED03
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [127:0]          seed,
  output logic [63:0]           rnd_o,
  output logic [NCORE*CW-1:0]   core_o
);
  localparam int SW = 64;

  function automatic logic [SW-1:0] rotl(input logic [SW-1:0] x, input int n);
    return (x << n) | (x >> (SW - n));
  endfunction

  logic [SW-1:0] s0, s1;

  wire [127:0]  seed_eff = (seed == '0) ? {ZS1, ZS0} : seed;
  wire [SW-1:0] t   = s0 ^ s1;
  wire [SW-1:0] n0  = rotl(s0, 24) ^ t ^ (t << 16);
  wire [SW-1:0] n1  = rotl(t, 37);
  wire [SW-1:0] m5  = (s0 << 2) + s0;
  wire [SW-1:0] r7  = rotl(m5, 7);
  wire [SW-1:0] scr = (r7 << 3) + r7;

  logic [NCORE*CW-1:0] core_d;

  for (genvar k = 0; k < NCORE; k++) begin : g_core
    for (genvar j = 0; j < CW; j++) begin : g_bit
      localparam int IDX = (j * (2 * k + 3) + 7 * k) % SW;
      assign core_d[k*CW+j] = scr[IDX];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0     <= seed_eff[SW-1:0];
      s1     <= seed_eff[127:SW];
      rnd_o  <= '0;
      core_o <= '0;
    end else begin
      s0     <= n0;
      s1     <= n1;
      rnd_o  <= scr;
      core_o <= core_d;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (rnd_o == '0 && core_o == '0));

  // R3 R4
  scramble_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> rnd_o == rotl($past(s0) * 64'd5, 7) * 64'd9);

  // R6
  state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) {s0, s1} != '0);

  // R6
  state_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> !$stable({s0, s1}));
endmodule

// File: tb/xrng_fanout_tb_top.sv
module xrng_fanout_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] seed = '0;
  logic [63:0]  rnd_o;
  logic [255:0] core_o;

  int checks = 0;
  int fails  = 0;
  logic [63:0] ms0, ms1;

  always #10 clk = ~clk;

  xrng_fanout dut_i (.clk(clk), .rst_n(rst_n), .seed(seed), .rnd_o(rnd_o), .core_o(core_o));

  function automatic logic [63:0] rl(input logic [63:0] x, input int n);
    return (x << n) | (x >> (64 - n));
  endfunction

  function automatic logic [63:0] scr(input logic [63:0] x);
    return rl(x * 64'd5, 7) * 64'd9;
  endfunction

  task automatic step_model();
    logic [63:0] t;
    t   = ms0 ^ ms1;
    ms0 = rl(ms0, 24) ^ t ^ (t << 16);
    ms1 = rl(t, 37);
  endtask

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_cores(input string req);
    logic [255:0] exp;
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 32; j++)
        exp[k*32+j] = rnd_o[(j * (2 * k + 3) + 7 * k) % 64];
    checks++;
    if (core_o !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, core_o, exp);
    end
  endtask

  // R1: hold reset, check cleared outputs, release
  task automatic do_reset(input logic [127:0] sd);
    @(negedge clk);
    rst_n = 1'b0;
    seed  = sd;
    repeat (2) @(negedge clk);
    check64("R1 rnd_o in reset", rnd_o, 64'h0);
    checks++;
    if (core_o !== '0) begin
      fails++;
      $display("FAIL R1 core_o in reset actual=%h expected=0", core_o);
    end
    if (sd == '0) begin
      ms0 = 64'h9E3779B97F4A7C15;
      ms1 = 64'hD1B54A32D192ED03;
    end else begin
      ms0 = sd[63:0];
      ms1 = sd[127:64];
    end
    rst_n = 1'b1;
  endtask

  task automatic run_cycles(input int n, input string req, input bit mess_seed);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check64(req, rnd_o, scr(ms0));
      check_cores("R7 core permutation");
      step_model();
      if (mess_seed) seed = {$urandom, $urandom, $urandom, $urandom};
    end
  endtask

  task automatic t_first_word();
    do_reset({64'h0123456789ABCDEF, 64'hFEDCBA9876543210});
    @(negedge clk);
    check64("R3 first word after reset", rnd_o, scr(64'hFEDCBA9876543210));
    step_model();
    run_cycles(40, "R4 R5 sequence", 1'b0);
  endtask

  task automatic t_zero_seed();
    do_reset('0);
    run_cycles(40, "R2 zero seed substitution", 1'b0);
  endtask

  task automatic t_seed_ignored();
    do_reset({64'h1, 64'h0});
    run_cycles(60, "R8 seed ignored while running", 1'b1);
  endtask

  task automatic t_ones_seed();
    do_reset({128{1'b1}});
    run_cycles(300, "R5 R6 long run all-ones seed", 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_first_word();
    t_zero_seed();
    t_seed_ignored();
    t_ones_seed();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule